// File: doc/BRIEF.md
# Pointer-Register Load/Store Address Unit

This unit forms the addresses that indirect loads and stores use. It takes the six pointer bytes from the register file and builds three 16-bit pointers, X, Y and Z. For each request it returns the data-memory address, the new value of the chosen pointer, a flag that says whether that value must be written back, and the number of cycles the access takes. The addressing mode can be plain, post-increment, pre-decrement or unsigned displacement. The cycle count depends on the mode, and loads and stores have different counts.

The unit also forms byte addresses for extended reads of program memory. It places an extension byte above Z, masked to the width that the configured program memory needs. With post-increment, a carry out of Z goes into the extension byte, and the combined value wraps to zero at the top of program memory.

The unit has no memories and no register file of its own. The caller applies the returned address and writes back the returned pointer values. A request is taken in one cycle, and its response is registered and valid in the next cycle.

Top module: `ptr_agu`

## Requirements
- R1: When `req_valid` is high at a clock edge, `rsp_valid` is high for the following cycle with the result of that request; otherwise `rsp_valid` is low. While `rst_n` is low at an edge, `rsp_valid` becomes low.
- R2: `ptr_regs` holds register bytes 26..31, with register 26+i at bits [8i+7:8i]. `req_sel` 0 selects X = {byte1, byte0}, 1 selects Y = {byte3, byte2}, 2 selects Z = {byte5, byte4}, and 3 also selects Z.
- R3: Post-increment (`req_mode` 1) on a data op: the address is the old pointer, `rsp_ptr` is pointer+1 (0xFFFF wraps to 0x0000) and `rsp_wb` is 1.
- R4: Pre-decrement (`req_mode` 2) on a data op: `rsp_ptr` is pointer-1 (0x0000 wraps to 0xFFFF), the address equals that new value and `rsp_wb` is 1.
- R5: Displacement (`req_mode` 3) on a data op: the address is pointer + unsigned `req_disp`, modulo 2^16. `rsp_wb` is 0 and `rsp_ptr` keeps the old pointer.
- R6: Plain (`req_mode` 0) on a data op: the address is the pointer, `rsp_wb` is 0 and `rsp_ptr` keeps the old pointer. On every data op, `rsp_ext` and `rsp_ext_wb` are 0 and the upper address bits above 15 are 0.
- R7: Load (`req_op` 0) cycle count is 1 for plain, 2 for post-increment, 3 for pre-decrement and 3 for displacement.
- R8: Store (`req_op` 1) cycle count is 1 for plain, 1 for post-increment, 2 for pre-decrement and 2 for displacement.
- R9: Program read (`req_op` 2 or 3) always uses Z, whatever `req_sel` is. The address is {masked extension, Z} and the cycle count is 3. Post-increment applies only when `req_mode` is 1. In any other mode, `rsp_wb` and `rsp_ext_wb` are 0 and `rsp_ptr` and `rsp_ext` carry the unchanged values.
- R10: Program read with post-increment: `{rsp_ext, rsp_ptr}` is {extension, Z}+1, modulo the program byte-address space. For example, extension 2 with Z 0xFFFF gives extension 3 with Z 0. With 128K words, extension 3 with Z 0xFFFF gives 0 and 0. Both `rsp_wb` and `rsp_ext_wb` are 1.
- R11: Only the low EXT_W bits of `req_ext` are used (EXT_W = 2 for the default 128K words). For example, 0x81 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 load, 1 store, 2 or 3 program read |
| req_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 or 3 Z |
| req_disp | input | 6 | Unsigned displacement |
| ptr_regs | input | 48 | Register bytes 26..31, low byte first |
| req_ext | input | 8 | Program extension byte |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 18 | Effective data address or program byte address |
| rsp_ptr | output | 16 | Pointer value to write back |
| rsp_ext | output | 8 | Extension value to write back |
| rsp_wb | output | 1 | Pointer write-back enable |
| rsp_ext_wb | output | 1 | Extension write-back enable |
| rsp_cycles | output | 2 | Access cycle count |

## Verification
The bench checks the pointer wrap in both directions: post-increment from 0xFFFF and pre-decrement from 0x0000. A design that wraps wrongly there would return a 17-bit value or a stale pointer. It drives a displacement that overflows 16 bits, and extended reads at Z = 0xFFFF with extension 2 and 3. A design that drops the carry would leave the extension unchanged, and one that fails to wrap would return 4 instead of 0. It also sends an extension byte with high bits set and program reads with X selected. The first case catches an unmasked address, and the second catches a design that reads X instead of Z. Each pointer pair holds distinct bytes, so a swapped byte order or wrong pairing gives a wrong address. Two requests in a row catch a response that is dropped or lags by a cycle.

// File: rtl/ptr_agu_pkg.sv
// Shared types for the pointer address unit.
// Assumes nothing beyond IEEE 1800-2017.
package ptr_agu_pkg;

    typedef enum logic [1:0] {
        AM_PLAIN = 2'd0,
        AM_POST  = 2'd1,
        AM_PRE   = 2'd2,
        AM_DISP  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_PROG  = 2'd2,
        OP_PROG2 = 2'd3
    } agu_op_e;

    localparam int PTR_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NPAIRS  = 3;
    localparam int CYC_W   = 2;

endpackage

// File: rtl/agu_ptr_pick.sv
// Builds the three pointer pairs from six register bytes and selects one.
// Assumes register 26+i sits at byte i of regs_i; even register is the low byte.
// A select of 3 picks the last pair (Z).
module agu_ptr_pick
    import ptr_agu_pkg::*;
(
    input  logic [2*NPAIRS*BYTE_W-1:0] regs_i,
    input  logic [1:0]                 sel_i,
    output logic [PTR_W-1:0]           ptr_o,
    output logic [PTR_W-1:0]           zptr_o
);
    logic [PTR_W-1:0] pair [NPAIRS];

    // Pair up consecutive bytes, low byte from the even register.
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        assign pair[p] = {regs_i[(2*p+1)*BYTE_W +: BYTE_W],
                          regs_i[(2*p)*BYTE_W   +: BYTE_W]};
    end

    // Select the requested pair; out-of-range selects fall onto Z.
    always_comb begin
        if (int'(sel_i) < NPAIRS) ptr_o = pair[sel_i];
        else                      ptr_o = pair[NPAIRS-1];
    end

    assign zptr_o = pair[NPAIRS-1];
endmodule

// File: rtl/agu_data_path.sv
// Data-memory address for one indirect access: effective address,
// updated pointer, write-back flag and cycle count by mode and direction.
// Assumes the displacement is unsigned and the arithmetic wraps at 16 bits.
module agu_data_path
    import ptr_agu_pkg::*;
#(
    parameter int DISP_W = 6
) (
    input  logic [PTR_W-1:0]  ptr_i,
    input  addr_mode_e        mode_i,
    input  logic              store_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PTR_W-1:0]  addr_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              wb_o,
    output logic [CYC_W-1:0]  cyc_o
);
    logic [PTR_W-1:0] inc_v;
    logic [PTR_W-1:0] dec_v;
    logic [PTR_W-1:0] off_v;

    // Candidate pointer arithmetic, all modulo 2^16.
    always_comb begin
        inc_v = ptr_i + PTR_W'(1);
        dec_v = ptr_i - PTR_W'(1);
        off_v = ptr_i + PTR_W'(disp_i);
    end

    // Address, write-back value and enable for the mode.
    always_comb begin
        addr_o = ptr_i;
        ptr_o  = ptr_i;
        wb_o   = 1'b0;
        unique case (mode_i)
            AM_PLAIN: ;
            AM_POST: begin
                ptr_o = inc_v;
                wb_o  = 1'b1;
            end
            AM_PRE: begin
                addr_o = dec_v;
                ptr_o  = dec_v;
                wb_o   = 1'b1;
            end
            AM_DISP: addr_o = off_v;
            default: ;
        endcase
    end

    // Cycle count: stores are one cycle shorter except in plain mode.
    always_comb begin
        unique case (mode_i)
            AM_PLAIN: cyc_o = CYC_W'(1);
            AM_POST:  cyc_o = store_i ? CYC_W'(1) : CYC_W'(2);
            AM_PRE:   cyc_o = store_i ? CYC_W'(2) : CYC_W'(3);
            AM_DISP:  cyc_o = store_i ? CYC_W'(2) : CYC_W'(3);
            default:  cyc_o = CYC_W'(1);
        endcase
    end
endmodule

// File: rtl/agu_prog_path.sv
// Extended program-memory byte address: extension bits above Z, with
// optional post-increment whose carry runs into the extension and wraps
// at the top of program memory.
// Assumes 1 <= EXT_W <= 8.
module agu_prog_path
    import ptr_agu_pkg::*;
#(
    parameter int EXT_W = 2,
    localparam int PAW  = PTR_W + EXT_W
) (
    input  logic [PTR_W-1:0] z_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic             post_i,
    output logic [PAW-1:0]   addr_o,
    output logic [PTR_W-1:0] z_o,
    output logic [BYTE_W-1:0] ext_o,
    output logic             wb_o
);
    logic [PAW-1:0] full_v;
    logic [PAW-1:0] next_v;

    // Concatenate and step the full byte address.
    always_comb begin
        full_v = {ext_i, z_i};
        next_v = full_v + PAW'(1);
    end

    // Split the stepped address back into Z and extension when requested.
    always_comb begin
        addr_o = full_v;
        wb_o   = post_i;
        if (post_i) begin
            z_o   = next_v[PTR_W-1:0];
            ext_o = BYTE_W'(next_v[PAW-1:PTR_W]);
        end else begin
            z_o   = z_i;
            ext_o = BYTE_W'(ext_i);
        end
    end
endmodule

// File: rtl/ptr_agu.sv
// Top of the pointer-register address unit. Selects the pointer, runs the
// data or program path by op, and registers the response one cycle later.
// Assumes PROG_WORDS is a power of two between 64K and 8M words.
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int PROG_WORDS = 131072,
    parameter int DISP_W     = 6,
    localparam int PAW       = $clog2(PROG_WORDS) + 1,
    localparam int EXT_W     = PAW - PTR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [1:0]            req_mode,
    input  logic [1:0]            req_sel,
    input  logic [DISP_W-1:0]     req_disp,
    input  logic [2*NPAIRS*BYTE_W-1:0] ptr_regs,
    input  logic [BYTE_W-1:0]     req_ext,
    output logic                  rsp_valid,
    output logic [PAW-1:0]        rsp_addr,
    output logic [PTR_W-1:0]      rsp_ptr,
    output logic [BYTE_W-1:0]     rsp_ext,
    output logic                  rsp_wb,
    output logic                  rsp_ext_wb,
    output logic [CYC_W-1:0]      rsp_cycles
);
    logic [PTR_W-1:0]  sel_ptr, z_ptr;
    logic [PTR_W-1:0]  d_addr, d_ptr;
    logic              d_wb;
    logic [CYC_W-1:0]  d_cyc;
    logic [PAW-1:0]    p_addr;
    logic [PTR_W-1:0]  p_z;
    logic [BYTE_W-1:0] p_ext;
    logic              p_wb;
    logic              is_prog;
    addr_mode_e        mode_e;
    logic              r_prog;
    addr_mode_e        r_mode;

    assign mode_e  = addr_mode_e'(req_mode);
    assign is_prog = req_op[1];

    // Unused high extension bits are dropped here.
    if (EXT_W < BYTE_W) begin : g_ext_sink
        logic unused_ext_hi;
        assign unused_ext_hi = ^req_ext[BYTE_W-1:EXT_W];
    end

    agu_ptr_pick u_pick (
        .regs_i (ptr_regs),
        .sel_i  (req_sel),
        .ptr_o  (sel_ptr),
        .zptr_o (z_ptr)
    );

    agu_data_path #(.DISP_W(DISP_W)) u_data (
        .ptr_i   (sel_ptr),
        .mode_i  (mode_e),
        .store_i (req_op == OP_STORE),
        .disp_i  (req_disp),
        .addr_o  (d_addr),
        .ptr_o   (d_ptr),
        .wb_o    (d_wb),
        .cyc_o   (d_cyc)
    );

    agu_prog_path #(.EXT_W(EXT_W)) u_prog (
        .z_i    (z_ptr),
        .ext_i  (req_ext[EXT_W-1:0]),
        .post_i (mode_e == AM_POST),
        .addr_o (p_addr),
        .z_o    (p_z),
        .ext_o  (p_ext),
        .wb_o   (p_wb)
    );

    // Response register: captures the path chosen by the op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_ptr    <= '0;
            rsp_ext    <= '0;
            rsp_wb     <= 1'b0;
            rsp_ext_wb <= 1'b0;
            rsp_cycles <= '0;
            r_prog     <= 1'b0;
            r_mode     <= AM_PLAIN;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                r_prog <= is_prog;
                r_mode <= mode_e;
                if (is_prog) begin
                    rsp_addr   <= p_addr;
                    rsp_ptr    <= p_z;
                    rsp_ext    <= p_ext;
                    rsp_wb     <= p_wb;
                    rsp_ext_wb <= p_wb;
                    rsp_cycles <= CYC_W'(3);
                end else begin
                    rsp_addr   <= PAW'(d_addr);
                    rsp_ptr    <= d_ptr;
                    rsp_ext    <= '0;
                    rsp_wb     <= d_wb;
                    rsp_ext_wb <= 1'b0;
                    rsp_cycles <= d_cyc;
                end
            end
        end
    end

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !r_prog && r_mode == AM_POST)
        |-> (rsp_wb && rsp_ptr == rsp_addr[PTR_W-1:0] + PTR_W'(1)));
    // R4
    pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !r_prog && r_mode == AM_PRE)
        |-> (rsp_wb && rsp_ptr == rsp_addr[PTR_W-1:0]));
    // R6
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !r_prog) |-> (rsp_addr[PAW-1:PTR_W] == '0 && !rsp_ext_wb));
    // R7
    cycles_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_cycles != '0);
    // R10
    prog_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ext_wb)
        |-> ({rsp_ext[EXT_W-1:0], rsp_ptr} == rsp_addr + PAW'(1)));
endmodule

// File: tb/tb_ptr_agu.sv
module tb_ptr_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0, req_mode = '0, req_sel = '0;
    logic [5:0]  req_disp = '0;
    logic [47:0] ptr_regs = '0;
    logic [7:0]  req_ext = '0;
    logic        rsp_valid, rsp_wb, rsp_ext_wb;
    logic [17:0] rsp_addr;
    logic [15:0] rsp_ptr;
    logic [7:0]  rsp_ext;
    logic [1:0]  rsp_cycles;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [17:0] addr;
        logic [15:0] ptr;
        logic [7:0]  ext;
        logic        wb;
        logic        ewb;
        logic [1:0]  cyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    ptr_agu dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mode(req_mode), .req_sel(req_sel), .req_disp(req_disp),
        .ptr_regs(ptr_regs), .req_ext(req_ext), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_ptr(rsp_ptr), .rsp_ext(rsp_ext),
        .rsp_wb(rsp_wb), .rsp_ext_wb(rsp_ext_wb), .rsp_cycles(rsp_cycles)
    );

    always #4 clk = ~clk;

    function automatic logic [47:0] mk_regs(logic [15:0] x, logic [15:0] y, logic [15:0] z);
        return {z[15:8], z[7:0], y[15:8], y[7:0], x[15:8], x[7:0]};
    endfunction

    // Reference model built from the requirement text.
    function automatic exp_t model(logic [1:0] op, logic [1:0] mode, logic [1:0] sel,
                                   logic [5:0] disp, logic [47:0] regs, logic [7:0] ext, string tag);
        exp_t e;
        logic [15:0] p;
        logic [17:0] full;
        e.tag = tag;
        if (op[1] || sel >= 2) p = {regs[47:40], regs[39:32]};
        else if (sel == 0)     p = {regs[15:8], regs[7:0]};
        else                   p = {regs[31:24], regs[23:16]};
        if (op[1]) begin
            full = {ext[1:0], p};
            e.addr = full; e.cyc = 3;
            if (mode == 1) begin
                full = full + 18'd1;
                e.ptr = full[15:0]; e.ext = {6'd0, full[17:16]}; e.wb = 1; e.ewb = 1;
            end else begin
                e.ptr = p; e.ext = {6'd0, ext[1:0]}; e.wb = 0; e.ewb = 0;
            end
        end else begin
            e.ext = 0; e.ewb = 0; e.ptr = p; e.wb = 0; e.addr = {2'b0, p};
            case (mode)
                2'd1: begin e.ptr = p + 16'd1; e.wb = 1; end
                2'd2: begin e.ptr = p - 16'd1; e.wb = 1; e.addr = {2'b0, p - 16'd1}; end
                2'd3: e.addr = {2'b0, p + {10'd0, disp}};
                default: ;
            endcase
            if (op == 0) e.cyc = (mode == 0) ? 2'd1 : (mode == 1) ? 2'd2 : 2'd3;
            else         e.cyc = (mode <= 1) ? 2'd1 : 2'd2;
        end
        return e;
    endfunction

    task automatic drive(logic [1:0] op, logic [1:0] mode, logic [1:0] sel,
                         logic [5:0] disp, logic [47:0] regs, logic [7:0] ext, string tag);
        @(negedge clk);
        req_valid = 1; req_op = op; req_mode = mode; req_sel = sel;
        req_disp = disp; ptr_regs = regs; req_ext = ext;
        @(posedge clk); #1;
        q.push_back(model(op, mode, sel, disp, regs, ext, tag));
        req_valid = 0;
    endtask

    // Monitor: pops expected items as responses appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (rsp_addr !== e.addr || rsp_ptr !== e.ptr || rsp_ext !== e.ext ||
                        rsp_wb !== e.wb || rsp_ext_wb !== e.ewb || rsp_cycles !== e.cyc) begin
                        failures++;
                        $display("FAIL %s actual addr=%h ptr=%h ext=%h wb=%b ewb=%b cyc=%0d expected addr=%h ptr=%h ext=%h wb=%b ewb=%b cyc=%0d",
                                 e.tag, rsp_addr, rsp_ptr, rsp_ext, rsp_wb, rsp_ext_wb, rsp_cycles,
                                 e.addr, e.ptr, e.ext, e.wb, e.ewb, e.cyc);
                    end
                end
            end else if (q.size() != 0) begin
                checks++; failures++;
                $display("FAIL R1 missing response: actual valid=0 expected valid=1");
                void'(q.pop_front());
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [47:0] rg;
    initial begin
        rg = mk_regs(16'h00C0, 16'h0080, 16'h0080);
        req_valid = 1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: actual valid=%b expected 0", rsp_valid);
        end
        @(negedge clk); req_valid = 0; rst_n = 1;
        @(negedge clk);

        drive(2'd0, 2'd0, 2'd0, 6'd0, mk_regs(16'h12C0, 16'h3480, 16'h5680), 8'h0, "R6 R7 R2 load plain X");
        drive(2'd0, 2'd1, 2'd0, 6'd0, mk_regs(16'h00C0, 16'h1111, 16'h2222), 8'h0, "R3 R7 load post X");
        drive(2'd0, 2'd2, 2'd1, 6'd0, mk_regs(16'hAAAA, 16'h0099, 16'h2222), 8'h0, "R4 R7 R2 load pre Y");
        drive(2'd0, 2'd3, 2'd1, 6'd2, mk_regs(16'hAAAA, 16'h0080, 16'h2222), 8'h0, "R5 R7 load disp Y+2");
        drive(2'd0, 2'd3, 2'd2, 6'd31, mk_regs(16'hAAAA, 16'hBBBB, 16'h0080), 8'h0, "R5 R2 load disp Z+31");
        drive(2'd1, 2'd0, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h0040), 8'h0, "R8 R6 store plain Z");
        drive(2'd1, 2'd1, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h0155), 8'h0, "R8 R3 store post Z");
        drive(2'd1, 2'd2, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h00FF), 8'h0, "R8 R4 store pre Z");
        drive(2'd1, 2'd3, 2'd1, 6'd17, mk_regs(16'hAAAA, 16'h009A, 16'hCCCC), 8'h0, "R8 R5 store disp Y+17");
        drive(2'd0, 2'd1, 2'd1, 6'd0, mk_regs(16'hAAAA, 16'hFFFF, 16'hCCCC), 8'h0, "R3 post wrap FFFF");
        drive(2'd1, 2'd2, 2'd0, 6'd0, mk_regs(16'h0000, 16'hBBBB, 16'hCCCC), 8'h0, "R4 pre wrap 0000");
        drive(2'd0, 2'd3, 2'd0, 6'd63, mk_regs(16'hFFF0, 16'hBBBB, 16'hCCCC), 8'h0, "R5 disp wrap");
        drive(2'd0, 2'd0, 2'd3, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h1357), 8'h0, "R2 select 3 is Z");
        drive(2'd2, 2'd0, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h0050), 8'h2, "R9 prog plain");
        drive(2'd2, 2'd1, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'hFFFF), 8'h2, "R10 prog carry 2->3");
        drive(2'd2, 2'd1, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'hFFFF), 8'h3, "R10 prog wrap top");
        drive(2'd3, 2'd0, 2'd2, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h0011), 8'h81, "R11 ext mask");
        drive(2'd2, 2'd3, 2'd0, 6'd5, mk_regs(16'hAAAA, 16'hBBBB, 16'h0123), 8'h1, "R9 prog ignores sel X");
        drive(2'd2, 2'd1, 2'd0, 6'd0, mk_regs(16'hAAAA, 16'hBBBB, 16'h7FFF), 8'hFE, "R11 R10 post masked ext");

        // Back-to-back requests, then idle.
        @(negedge clk);
        req_valid = 1; req_op = 0; req_mode = 1; req_sel = 0; ptr_regs = mk_regs(16'h0010, 0, 0);
        @(posedge clk); #1;
        q.push_back(model(2'd0, 2'd1, 2'd0, 6'd0, mk_regs(16'h0010, 0, 0), 8'h0, "R1 back-to-back a"));
        @(negedge clk);
        req_op = 1; req_mode = 2; req_sel = 1; ptr_regs = mk_regs(0, 16'h0020, 0);
        @(posedge clk); #1;
        q.push_back(model(2'd1, 2'd2, 2'd1, 6'd0, mk_regs(0, 16'h0020, 0), 8'h0, "R1 back-to-back b"));
        req_valid = 0;
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R1 leftover: actual pending=%0d expected 0", q.size());
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule